// File: doc/BRIEF.md
# Periodic Frame End Interrupt Timer

The block measures elapsed clock cycles inside each USB interval. A full-speed frame and a high-speed microframe are both intervals. A start-of-frame pulse restarts the measurement. The block raises a single-cycle interrupt once a programmable share of the interval has passed. Software uses that interrupt to check whether the isochronous traffic of the current interval has completed before the next interval begins.

A 2-bit select input picks the share: 80, 85, 90 or 95 percent. The same four shares apply at both speeds. Each threshold is computed at elaboration from the interval lengths, which are parameters. At a 60 MHz clock they default to 7500 cycles (microframe) and 60000 cycles (frame). Alongside the pulse, a sticky status flag records the event until software clears it with a write-one-to-clear strobe.

Top module: `eopf_timer`

## Requirements
- R1: The threshold is floor(N*P/100) cycles. P is 80, 85, 90 or 95 for sel_i codes 0, 1, 2 and 3. irq_o rises exactly that many cycles after the clock edge that samples sof_i high.
- R2: N is HS_CYCLES when hs_i=1 (microframe) and FS_CYCLES when hs_i=0 (frame). The same four percentages apply at both speeds.
- R3: After reset, irq_o and sts_o are 0. No interrupt occurs before the first start-of-frame pulse.
- R4: irq_o is high for exactly one cycle. It fires at most once per interval, even when the next start-of-frame pulse is late.
- R5: Each sof_i pulse restarts the count from zero. If sof_i is sampled at or before the threshold edge, no interrupt is produced for the interval it ends.
- R6: sts_o rises in the same cycle as irq_o and holds until a cycle with clr_i=1. A clr_i with no interrupt pending leaves sts_o at 0. If an interrupt and clr_i coincide, sts_o stays set.
- R7: hs_i and sel_i are sampled only on the sof_i edge. Changing them mid-interval does not move the current interval's interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse, one cycle |
| hs_i | input | 1 | 1: high-speed microframe, 0: full-speed frame |
| sel_i | input | 2 | Threshold select: 0=80%, 1=85%, 2=90%, 3=95% |
| clr_i | input | 1 | Write-one-to-clear strobe for sts_o |
| irq_o | output | 1 | End-of-periodic-frame interrupt pulse |
| sts_o | output | 1 | Sticky interrupt status |

## Verification
The assertions check four properties on every cycle:
- The pulse lasts a single cycle.
- A sampled start-of-frame suppresses the pulse at the next edge.
- The status flag is set whenever the pulse is present and falls only after a clear.
- The running count never reaches the latched threshold while the timer is armed.

Only the bench scenarios can show the following:
- The exact cycle of the pulse for every speed and code.
- Suppression when the next start-of-frame arrives exactly at the threshold.
- A single pulse across a long late interval.
- Immunity to mid-interval changes of the select inputs.

// File: rtl/eopf_pkg.sv
package eopf_pkg;
  typedef logic [1:0] pct_sel_t;
  localparam int unsigned NUM_SEL = 4;

  function automatic int unsigned pct_of(input int unsigned code);
    return 32'd80 + 32'd5 * code;
  endfunction
endpackage

// File: rtl/eopf_thresh.sv
module eopf_thresh
  import eopf_pkg::*;
#(
  parameter int unsigned HS_CYCLES = 7500,
  parameter int unsigned FS_CYCLES = 60000,
  parameter int unsigned CW        = 16
) (
  input  logic          hs_i,
  input  pct_sel_t      sel_i,
  output logic [CW-1:0] thr_o
);
  logic [CW-1:0] hs_tab [NUM_SEL];
  logic [CW-1:0] fs_tab [NUM_SEL];

  for (genvar c = 0; c < NUM_SEL; c++) begin : g_tab
    localparam int unsigned HS_T = HS_CYCLES * pct_of(c) / 100;
    localparam int unsigned FS_T = FS_CYCLES * pct_of(c) / 100;
    assign hs_tab[c] = CW'(HS_T);
    assign fs_tab[c] = CW'(FS_T);
  end

  assign thr_o = hs_i ? hs_tab[sel_i] : fs_tab[sel_i];
endmodule

// File: rtl/eopf_counter.sv
module eopf_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_i,
  input  logic [CW-1:0] thr_i,
  output logic          fire_set_o,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q, thr_q, cnt_inc;
  logic          armed_q, fire_q;

  assign cnt_inc    = cnt_q + CW'(1);
  // threshold reached at this edge
  assign fire_set_o = !sof_i && armed_q && (cnt_inc == thr_q);
  assign fire_o     = fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      thr_q   <= '0;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else if (sof_i) begin
      cnt_q   <= '0;
      thr_q   <= thr_i;
      armed_q <= 1'b1;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= fire_set_o;
      if (armed_q) begin
        cnt_q <= cnt_inc;
        if (fire_set_o) armed_q <= 1'b0;
      end
    end
  end

  assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);
  assert_sof_suppresses_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> !fire_q);
  assert_count_below_thr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (cnt_q < thr_q));
endmodule

// File: rtl/eopf_status.sv
module eopf_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  logic sts_q;

  // set wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= 1'b0;
    else         sts_q <= set_i | (sts_q & ~clr_i);
  end

  assign sts_o = sts_q;

  assert_fall_needs_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts_q) |-> $past(clr_i));
  assert_set_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> sts_q);
endmodule

// File: rtl/eopf_timer.sv
module eopf_timer
  import eopf_pkg::*;
#(
  parameter int unsigned HS_CYCLES = 7500,
  parameter int unsigned FS_CYCLES = 60000,
  localparam int unsigned CW = $clog2(FS_CYCLES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sof_i,
  input  logic       hs_i,
  input  logic [1:0] sel_i,
  input  logic       clr_i,
  output logic       irq_o,
  output logic       sts_o
);
  logic [CW-1:0] thr;
  logic          fire_set, fire;

  eopf_thresh #(.HS_CYCLES(HS_CYCLES), .FS_CYCLES(FS_CYCLES), .CW(CW)) u_thresh (
    .hs_i  (hs_i),
    .sel_i (pct_sel_t'(sel_i)),
    .thr_o (thr)
  );

  eopf_counter #(.CW(CW)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .thr_i      (thr),
    .fire_set_o (fire_set),
    .fire_o     (fire)
  );

  eopf_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fire_set),
    .clr_i  (clr_i),
    .sts_o  (sts_o)
  );

  assign irq_o = fire;

  assert_irq_sets_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sts_o);
  assert_irq_no_x_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({irq_o, sts_o}));
endmodule

// File: tb/eopf_timer_tb_top.sv
`timescale 1ns/1ps
module eopf_timer_tb_top;
  localparam int unsigned HS_N = 40;
  localparam int unsigned FS_N = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sof_i = 1'b0, hs_i = 1'b0, clr_i = 1'b0;
  logic [1:0] sel_i = 2'd0;
  logic irq_o, sts_o;
  int total = 0, bad = 0;
  bit sts_exp = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  eopf_timer #(.HS_CYCLES(HS_N), .FS_CYCLES(FS_N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof_i), .hs_i(hs_i),
    .sel_i(sel_i), .clr_i(clr_i), .irq_o(irq_o), .sts_o(sts_o));

  function automatic int calc(input bit hs, input int code);
    return int'(hs ? HS_N : FS_N) * (80 + 5 * code) / 100;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one interval of len cycles; chg>0 flips hs/sel after sample k==chg
  task automatic run_iv(input bit hs, input int code, input int len,
                        input int chg, input string req);
    int thr, hits, pos;
    thr = calc(hs, code); hits = 0; pos = -1;
    @(negedge clk); sof_i = 1'b1; hs_i = hs; sel_i = 2'(code);
    @(negedge clk); sof_i = 1'b0;
    for (int k = 1; k < len; k++) begin
      @(posedge clk); #1;
      if (irq_o) begin hits++; pos = k; end
      if (k == chg) begin hs_i = !hs; sel_i = ~sel_i; end
    end
    if (thr < len) begin
      sts_exp = 1'b1;
      check(hits == 1 && pos == thr, {req, " pulse position"}, pos, thr);
    end else begin
      check(hits == 0, {req, " no pulse"}, hits, 0);
    end
    check(sts_o == sts_exp, {req, " status"}, int'(sts_o), int'(sts_exp));
  endtask

  task automatic do_clear();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    sts_exp = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    finish_run();
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_o == 1'b0 && sts_o == 1'b0, "R3 reset state", int'({irq_o, sts_o}), 0);
    t = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (irq_o) t++; end
    check(t == 0 && sts_o == 1'b0, "R3 idle before first sof", t, 0);

    // R1/R2 sweep: all codes, both speeds, fired/at-threshold/early
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        t = calc(s[0], c);
        run_iv(s[0], c, t + 5, 0, s ? "R1 R2 hs" : "R1 R2 fs");
        run_iv(s[0], c, t, 0, "R5 sof at threshold");
        run_iv(s[0], c, t - 1, 0, "R5 early sof");
      end
    end

    // R4: late sof, single pulse over a long interval
    run_iv(1'b1, 3, 3 * HS_N, 0, "R4 late sof");
    run_iv(1'b0, 0, 2 * FS_N, 0, "R4 late sof fs");

    // R7: mid-interval change of speed and select
    run_iv(1'b1, 0, HS_N, 5, "R7 hs->fs change");
    run_iv(1'b0, 3, FS_N, 7, "R7 fs->hs change");

    // R6 sticky and clear
    run_iv(1'b1, 1, HS_N, 0, "R6 sticky hold");
    do_clear();
    check(sts_o == 1'b0, "R6 clear", int'(sts_o), 0);
    do_clear();
    check(sts_o == 1'b0, "R6 clear while idle", int'(sts_o), 0);

    // R6 coincident set and clear: clr_i at the firing edge
    @(negedge clk); sof_i = 1'b1; hs_i = 1'b1; sel_i = 2'd0;
    @(negedge clk); sof_i = 1'b0;
    repeat (calc(1'b1, 0) - 1) @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    check(irq_o == 1'b1, "R6 coincident pulse", int'(irq_o), 1);
    check(sts_o == 1'b1, "R6 set wins over clear", int'(sts_o), 1);
    @(negedge clk);
    check(irq_o == 1'b0, "R4 pulse width one", int'(irq_o), 0);
    do_clear();
    check(sts_o == 1'b0, "R6 final clear", int'(sts_o), 0);

    finish_run();
  end
endmodule